// File: doc/BRIEF.md
# Half-Duplex Back-Pressure Controller

This block decides, for one external port of a small switch, when that port must push back on its link partner in half-duplex operation. It watches the fill level of two other buffers: the internal (host) port buffer and the buffer of the second external port. When either buffer is close to full, it raises a back-pressure flag. The flag clears only when both buffers have drained well below that point, so the flag does not toggle rapidly.

Back pressure is only meaningful on a shared medium. The flag can therefore only be set while both external ports run at the same speed and both are in half duplex. While the flag is set, queued frames still go out normally. When the port has nothing to send, the block asks the MAC to transmit short bursts of preamble bytes, with a fixed idle gap between bursts. Each burst occupies the carrier long enough that the neighbouring station defers.

The MAC takes each preamble byte over a valid/ready handshake. Occupancy and capacity arrive as plain counts. The on and off points are integer fractions of capacity.

Top module: `hdbp_ctrl`

## Requirements
- R1: Unless both external ports report equal speed codes and both half-duplex flags are 1, `bp_active` is 0 on the clock edge after that input state is sampled, whatever the buffer levels are.
- R2: With the port condition of R1 met, if either buffer satisfies occupancy×100 ≥ capacity×95, `bp_active` is 1 on the next clock edge.
- R3: Once set, `bp_active` clears on the next edge only when both buffers satisfy occupancy×100 < capacity×85. For levels between the two points it keeps its previous value.
- R4: A new preamble burst starts only while `bp_active` is 1 and `frame_pending` is 0. A frame that is pending when a burst would otherwise start wins, and no burst starts.
- R5: A burst is exactly BURST_LEN accepted bytes (default 8), each with `jam_data` = 8'h55. A byte is accepted on an edge where `jam_valid` and `tx_ready` are both 1. `jam_valid` stays high while `tx_ready` is low.
- R6: A burst that has started always completes all BURST_LEN bytes, even if `bp_active` falls or the port condition of R1 is lost during the burst.
- R7: After each burst, `jam_valid` is low for exactly GAP_LEN clocks (default 12). The next burst then starts at once if R4 allows it.
- R8: After synchronous reset, `bp_active` and `jam_valid` are 0 and `jam_data` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_speed | input | 2 | Speed code of this external port (compared for equality only) |
| own_half | input | 1 | 1 = this port is in half duplex |
| peer_speed | input | 2 | Speed code of the other external port |
| peer_half | input | 1 | 1 = other external port is in half duplex |
| host_occ | input | OCC_W | Internal-port buffer occupancy |
| host_cap | input | OCC_W | Internal-port buffer capacity |
| peer_occ | input | OCC_W | Other external-port buffer occupancy |
| peer_cap | input | OCC_W | Other external-port buffer capacity |
| frame_pending | input | 1 | A frame is queued for transmission on this port |
| tx_ready | input | 1 | MAC accepts the offered preamble byte |
| bp_active | output | 1 | Back pressure is in force |
| jam_valid | output | 1 | A preamble byte is offered to the MAC |
| jam_data | output | 8 | Offered preamble byte |

## Verification
Two things can happen in the same cycle: the back-pressure decision can drop, and the preamble generator can be partway through a burst. The bench provokes this by breaking the speed match three bytes into a burst. It then expects `bp_active` to fall one edge later while `jam_valid` stays high for the rest of the eight bytes, with no burst after that. A second collision is a frame becoming pending just as the inter-burst gap expires. In that case the bench expects the gap to run into silence rather than into a new burst.

// File: rtl/hdbp_pkg.sv
package hdbp_pkg;
  typedef enum logic [1:0] {
    JAM_IDLE  = 2'd0,
    JAM_BURST = 2'd1,
    JAM_GAP   = 2'd2
  } jam_state_e;

  localparam logic [7:0] PREAMBLE_BYTE = 8'h55;
  localparam int unsigned NUM_WATCHED = 2;
endpackage

// File: rtl/hdbp_thresh.sv
module hdbp_thresh #(
  parameter int unsigned OCC_W  = 12,
  parameter int unsigned HI_PCT = 95,
  parameter int unsigned LO_PCT = 85
) (
  input  logic [OCC_W-1:0] occ,
  input  logic [OCC_W-1:0] cap,
  output logic             at_high,
  output logic             below_low
);
  localparam int unsigned PROD_W = OCC_W + 8;

  logic [PROD_W-1:0] occ_scaled;
  logic [PROD_W-1:0] hi_mark;
  logic [PROD_W-1:0] lo_mark;

  always_comb begin
    occ_scaled = PROD_W'(occ) * PROD_W'(100);
    hi_mark    = PROD_W'(cap) * PROD_W'(HI_PCT);
    lo_mark    = PROD_W'(cap) * PROD_W'(LO_PCT);
    at_high    = (occ_scaled >= hi_mark);
    below_low  = (occ_scaled < lo_mark);
  end
endmodule

// File: rtl/hdbp_decide.sv
module hdbp_decide #(
  parameter int unsigned NUM_BUF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eligible,
  input  logic [NUM_BUF-1:0] at_high,
  input  logic [NUM_BUF-1:0] below_low,
  output logic               bp_q
);
  logic bp_d;

  always_comb begin
    bp_d = bp_q;
    if (!eligible)
      bp_d = 1'b0;
    else if (|at_high)
      bp_d = 1'b1;
    else if (&below_low)
      bp_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) bp_q <= 1'b0;
    else     bp_q <= bp_d;
  end
endmodule

// File: rtl/hdbp_jam.sv
module hdbp_jam
  import hdbp_pkg::*;
#(
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned GAP_LEN   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bp_on,
  input  logic       frame_pending,
  input  logic       tx_ready,
  output logic       jam_valid,
  output logic [7:0] jam_data
);
  localparam int unsigned MAX_LEN = (BURST_LEN > GAP_LEN) ? BURST_LEN : GAP_LEN;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  jam_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             may_start;

  assign may_start = bp_on && !frame_pending;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      JAM_IDLE: begin
        if (may_start) begin
          state_d = JAM_BURST;
          cnt_d   = '0;
        end
      end
      JAM_BURST: begin
        if (tx_ready) begin
          if (cnt_q == CNT_W'(BURST_LEN - 1)) begin
            state_d = JAM_GAP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      JAM_GAP: begin
        if (cnt_q == CNT_W'(GAP_LEN - 1)) begin
          cnt_d   = '0;
          state_d = may_start ? JAM_BURST : JAM_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = JAM_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= JAM_IDLE;
      cnt_q     <= '0;
      jam_valid <= 1'b0;
      jam_data  <= 8'h00;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      jam_valid <= (state_d == JAM_BURST);
      jam_data  <= (state_d == JAM_BURST) ? PREAMBLE_BYTE : 8'h00;
    end
  end
endmodule

// File: rtl/hdbp_ctrl.sv
module hdbp_ctrl
  import hdbp_pkg::*;
#(
  parameter int unsigned OCC_W     = 12,
  parameter int unsigned HI_PCT    = 95,
  parameter int unsigned LO_PCT    = 85,
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned GAP_LEN   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       own_speed,
  input  logic             own_half,
  input  logic [1:0]       peer_speed,
  input  logic             peer_half,
  input  logic [OCC_W-1:0] host_occ,
  input  logic [OCC_W-1:0] host_cap,
  input  logic [OCC_W-1:0] peer_occ,
  input  logic [OCC_W-1:0] peer_cap,
  input  logic             frame_pending,
  input  logic             tx_ready,
  output logic             bp_active,
  output logic             jam_valid,
  output logic [7:0]       jam_data
);
  logic [OCC_W-1:0]       occ_v [NUM_WATCHED];
  logic [OCC_W-1:0]       cap_v [NUM_WATCHED];
  logic [NUM_WATCHED-1:0] hi_v;
  logic [NUM_WATCHED-1:0] lo_v;
  logic                   eligible;

  assign occ_v[0] = host_occ;
  assign cap_v[0] = host_cap;
  assign occ_v[1] = peer_occ;
  assign cap_v[1] = peer_cap;

  assign eligible = (own_speed == peer_speed) && own_half && peer_half;

  for (genvar g = 0; g < NUM_WATCHED; g++) begin : g_watch
    hdbp_thresh #(
      .OCC_W (OCC_W),
      .HI_PCT(HI_PCT),
      .LO_PCT(LO_PCT)
    ) u_thresh (
      .occ      (occ_v[g]),
      .cap      (cap_v[g]),
      .at_high  (hi_v[g]),
      .below_low(lo_v[g])
    );
  end

  hdbp_decide #(
    .NUM_BUF(NUM_WATCHED)
  ) u_decide (
    .clk      (clk),
    .rst      (rst),
    .eligible (eligible),
    .at_high  (hi_v),
    .below_low(lo_v),
    .bp_q     (bp_active)
  );

  hdbp_jam #(
    .BURST_LEN(BURST_LEN),
    .GAP_LEN  (GAP_LEN)
  ) u_jam (
    .clk          (clk),
    .rst          (rst),
    .bp_on        (bp_active),
    .frame_pending(frame_pending),
    .tx_ready     (tx_ready),
    .jam_valid    (jam_valid),
    .jam_data     (jam_data)
  );
endmodule

// File: rtl/hdbp_ctrl_chk.sv
module hdbp_ctrl_chk #(
  parameter int unsigned OCC_W  = 12,
  parameter int unsigned HI_PCT = 95,
  parameter int unsigned LO_PCT = 85
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       own_speed,
  input logic             own_half,
  input logic [1:0]       peer_speed,
  input logic             peer_half,
  input logic [OCC_W-1:0] host_occ,
  input logic [OCC_W-1:0] host_cap,
  input logic [OCC_W-1:0] peer_occ,
  input logic [OCC_W-1:0] peer_cap,
  input logic             frame_pending,
  input logic             tx_ready,
  input logic             bp_active,
  input logic             jam_valid,
  input logic [7:0]       jam_data
);
  localparam int unsigned PW = OCC_W + 8;

  logic ok_link, any_full, all_drained;
  assign ok_link  = (own_speed == peer_speed) && own_half && peer_half;
  assign any_full = (PW'(host_occ) * PW'(100) >= PW'(host_cap) * PW'(HI_PCT)) ||
                    (PW'(peer_occ) * PW'(100) >= PW'(peer_cap) * PW'(HI_PCT));
  assign all_drained = (PW'(host_occ) * PW'(100) < PW'(host_cap) * PW'(LO_PCT)) &&
                       (PW'(peer_occ) * PW'(100) < PW'(peer_cap) * PW'(LO_PCT));

  AST_LINK_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    !ok_link |=> !bp_active); // R1
  AST_FULL_SETS_BP: assert property (@(posedge clk) disable iff (rst)
    (ok_link && any_full) |=> bp_active); // R2
  AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (ok_link && !any_full && !all_drained) |=> (bp_active == $past(bp_active))); // R3
  AST_PENDING_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    (!jam_valid && frame_pending) |=> !jam_valid); // R4
  AST_IDLE_NEEDS_BP: assert property (@(posedge clk) disable iff (rst)
    (!jam_valid && !bp_active) |=> !jam_valid); // R4
  AST_PREAMBLE_VALUE: assert property (@(posedge clk) disable iff (rst)
    jam_valid |-> (jam_data == 8'h55)); // R5
  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (jam_valid && !tx_ready) |=> jam_valid); // R6
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !jam_valid |-> (jam_data == 8'h00)); // R8
endmodule

bind hdbp_ctrl hdbp_ctrl_chk #(
  .OCC_W (OCC_W),
  .HI_PCT(HI_PCT),
  .LO_PCT(LO_PCT)
) u_chk (.*);

// File: tb/hdbp_ctrl_tb_top.sv
`timescale 1ns/1ps
module hdbp_ctrl_tb_top;
  localparam int OCC_W = 12;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       own_speed, peer_speed;
  logic             own_half, peer_half;
  logic [OCC_W-1:0] host_occ, host_cap, peer_occ, peer_cap;
  logic             frame_pending, tx_ready;
  logic             bp_active, jam_valid;
  logic [7:0]       jam_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hdbp_ctrl #(.OCC_W(OCC_W)) dut_i (
    .clk(clk), .rst(rst),
    .own_speed(own_speed), .own_half(own_half),
    .peer_speed(peer_speed), .peer_half(peer_half),
    .host_occ(host_occ), .host_cap(host_cap),
    .peer_occ(peer_occ), .peer_cap(peer_cap),
    .frame_pending(frame_pending), .tx_ready(tx_ready),
    .bp_active(bp_active), .jam_valid(jam_valid), .jam_data(jam_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lvl(input int ho, input int hc, input int po, input int pc);
    host_occ = OCC_W'(ho); host_cap = OCC_W'(hc);
    peer_occ = OCC_W'(po); peer_cap = OCC_W'(pc);
  endtask

  // Waits for a burst, returns its high length and the following low length.
  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    for (int i = 0; i < 100 && !jam_valid; i++) tick();
    for (int i = 0; i < 100 && jam_valid; i++) begin hi++; tick(); end
    for (int i = 0; i < 100 && !jam_valid; i++) begin lo++; tick(); end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    own_speed = 2'd1; peer_speed = 2'd1; own_half = 1'b1; peer_half = 1'b1;
    set_lvl(0, 100, 0, 100);
    frame_pending = 1'b1; tx_ready = 1'b1;
    tick(3);
    rst = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 bp_active", bp_active, 0);
    chk("R8 jam_valid", jam_valid, 0);
    chk("R8 jam_data", jam_data, 0);
  endtask

  task automatic t_set_point();
    do_reset();
    set_lvl(94, 100, 0, 100); tick();
    chk("R2 below 95% stays off", bp_active, 0);
    set_lvl(95, 100, 0, 100); tick();
    chk("R2 host at 95% one cycle later", bp_active, 1);
    do_reset();
    set_lvl(0, 200, 189, 200); tick();
    chk("R2 peer 189/200 stays off", bp_active, 0);
    set_lvl(0, 200, 190, 200); tick();
    chk("R2 peer 190/200 sets", bp_active, 1);
  endtask

  task automatic t_hysteresis();
    do_reset();
    set_lvl(100, 100, 0, 100); tick();
    set_lvl(90, 100, 0, 100); tick(3);
    chk("R3 holds in band", bp_active, 1);
    set_lvl(0, 100, 85, 100); tick(2);
    chk("R3 peer at 85% still holds", bp_active, 1);
    set_lvl(84, 100, 84, 100); tick();
    chk("R3 both below 85% clears", bp_active, 0);
    set_lvl(90, 100, 90, 100); tick(2);
    chk("R3 band after clear stays off", bp_active, 0);
  endtask

  task automatic t_link_gate();
    do_reset();
    peer_speed = 2'd2; set_lvl(100, 100, 100, 100); tick(2);
    chk("R1 speed mismatch forced off", bp_active, 0);
    peer_speed = 2'd1; own_half = 1'b0; tick(2);
    chk("R1 full duplex forced off", bp_active, 0);
    own_half = 1'b1; tick();
    chk("R1 matched half duplex allows", bp_active, 1);
    peer_half = 1'b0; tick();
    chk("R1 loss clears next cycle", bp_active, 0);
  endtask

  task automatic t_burst_gap();
    int hi, lo, bad;
    do_reset();
    frame_pending = 1'b0;
    set_lvl(100, 100, 0, 100);
    bad = 0;
    for (int i = 0; i < 100 && !jam_valid; i++) tick();
    for (int i = 0; i < 100 && jam_valid; i++) begin
      if (jam_data != 8'h55) bad++;
      tick();
    end
    chk("R5 preamble byte value", bad, 0);
    measure(hi, lo);
    chk("R5 burst length", hi, 8);
    chk("R7 gap length", lo, 12);
  endtask

  task automatic t_stall();
    int hi;
    do_reset();
    frame_pending = 1'b0;
    set_lvl(100, 100, 0, 100);
    for (int i = 0; i < 100 && !jam_valid; i++) tick();
    hi = 0;
    for (int i = 0; i < 100 && jam_valid; i++) begin
      tx_ready = (i % 2 == 0);
      if (tx_ready) hi++;
      tick();
    end
    tx_ready = 1'b1;
    chk("R5 accepted bytes with stalls", hi, 8);
  endtask

  task automatic t_pending();
    int seen, hi, lo;
    do_reset();
    frame_pending = 1'b1;
    set_lvl(100, 100, 0, 100);
    seen = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (jam_valid) seen++; end
    chk("R4 no burst while frame pending", seen, 0);
    frame_pending = 1'b0; tick(2);
    chk("R4 burst once frame gone", jam_valid, 1);
    for (int i = 0; i < 100 && jam_valid; i++) tick();
    frame_pending = 1'b1;
    seen = 0;
    for (int i = 0; i < 30; i++) begin tick(); if (jam_valid) seen++; end
    chk("R4 pending at gap end wins", seen, 0);
    frame_pending = 1'b0;
    measure(hi, lo);
    chk("R7 bursts resume", hi, 8);
  endtask

  task automatic t_no_truncate();
    int hi, seen;
    do_reset();
    frame_pending = 1'b0;
    set_lvl(100, 100, 0, 100);
    for (int i = 0; i < 100 && !jam_valid; i++) tick();
    hi = 0;
    for (int i = 0; i < 3; i++) begin hi++; tick(); end
    peer_speed = 2'd0;
    tick();
    chk("R1 bp drops mid burst", bp_active, 0);
    hi++;
    for (int i = 0; i < 100 && jam_valid; i++) begin hi++; tick(); end
    chk("R6 burst completes after loss", hi, 8);
    seen = 0;
    for (int i = 0; i < 40; i++) begin tick(); if (jam_valid) seen++; end
    chk("R4 no further burst without bp", seen, 0);
  endtask

  initial begin
    t_reset();
    t_set_point();
    t_hysteresis();
    t_link_gate();
    t_burst_gap();
    t_stall();
    t_pending();
    t_no_truncate();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule